// File: doc/BRIEF.md
# Processor Breakpoint and Single-Step Controller

This block decides, cycle by cycle, whether a soft processor core may advance. It watches the program address and the instruction word the core presents, and compares each with a host-chosen watch value. Each comparison has its own enable bit. When an enabled comparison matches, the controller raises a hit flag and withholds permission to execute in that same cycle. It then stays halted until the host issues a new start strobe.

The host can also request a bounded run of steps. A one-cycle start strobe loads a step budget. The core then executes once per cycle until that budget is used up, or until a watch hit ends the run early. A run-always bit lets the core execute on every cycle regardless of the budget, although a watch hit still stops it. A hold-in-reset bit is ORed with the system reset to form the core's reset. The core's clock enable is the execute permission ORed with system reset, so that reset is always clocked into the core.

Top module: `dbg_step_gate`

## Requirements
- R1: `watch_hit_o` is 1 in the same cycle when `watch_en_i[0]` is 1 and `pc_addr_i` equals `watch_addr_i`.
- R2: `watch_hit_o` is 1 in the same cycle when `watch_en_i[1]` is 1 and `insn_i` equals `watch_insn_i`.
- R3: A comparison whose enable bit is 0 never raises `watch_hit_o`, and a mismatch in any single bit gives no hit.
- R4: In the cycle after a `step_go_i` pulse with no hit present, `stepping_o` is 1 exactly when `step_num_i` was nonzero.
- R5: After a start with N requested steps and run-always low, `may_exec_o` is high for exactly N cycles. It is then low, with `stepping_o` low.
- R6: In a cycle with a hit, `may_exec_o` is 0. In the next cycle the step budget is zero (`stepping_o` = 0).
- R7: After a hit, `may_exec_o` stays 0, even with run-always set, until a `step_go_i` pulse. Execution resumes in the cycle after that pulse.
- R8: With `run_always_i` = 1, no hit present and no halt pending, `may_exec_o` is 1 on every cycle, whatever the step budget.
- R9: `core_rst_o` is the OR of `rst` and `hold_rst_i`, with no delay.
- R10: `core_clk_en_o` is the OR of `may_exec_o` and `rst`, with no delay.
- R11: After a reset with `run_always_i` = 0, `stepping_o` and `may_exec_o` are 0 and no halt is pending.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous system reset, active high |
| pc_addr_i | input | ADDR_W (13) | Current program address of the core |
| insn_i | input | INSN_W (14) | Instruction word being fetched |
| watch_addr_i | input | ADDR_W (13) | Address watch value |
| watch_insn_i | input | INSN_W (14) | Instruction watch value |
| watch_en_i | input | 2 | Bit 0 enables the address compare, bit 1 enables the instruction compare |
| step_num_i | input | STEP_W (6) | Step budget loaded on a start |
| step_go_i | input | 1 | One-cycle start strobe |
| run_always_i | input | 1 | Execute on every cycle regardless of the budget |
| hold_rst_i | input | 1 | Hold the core in reset |
| may_exec_o | output | 1 | Core may execute this cycle |
| watch_hit_o | output | 1 | An enabled watch compare matches |
| stepping_o | output | 1 | Step budget is nonzero |
| core_rst_o | output | 1 | Reset to the core |
| core_clk_en_o | output | 1 | Clock enable to the core |

## Verification
The hit flag, the core reset and the core clock enable are combinational. The bench therefore samples them one nanosecond after it changes the inputs, within the same cycle. The step budget and the halt state are registered, so their effects on `stepping_o` and `may_exec_o` appear one edge after the strobe or the hit. The bench drives inputs on the falling edge and samples just before the next rising edge. Execute cycles are counted from the first cycle after the loading edge. A sweep over every budget from 0 to 63 therefore expects exactly N permitted cycles.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
    // bit positions inside the two-bit watch enable field
    localparam int WEN_ADDR = 0;
    localparam int WEN_INSN = 1;
    localparam int WEN_W    = 2;
endpackage

// File: rtl/dbg_watch_cmp.sv
module dbg_watch_cmp #(
    parameter int W = 13
) (
    input  logic         en_i,
    input  logic [W-1:0] live_i,
    input  logic [W-1:0] ref_i,
    output logic         hit_o
);
    logic same;

    always_comb begin
        same  = (live_i == ref_i);
        hit_o = en_i && same;
    end
endmodule

// File: rtl/dbg_step_ctrl.sv
module dbg_step_ctrl #(
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hit_i,
    input  logic              go_i,
    input  logic [STEP_W-1:0] num_i,
    input  logic              run_always_i,
    output logic              may_exec_o,
    output logic              stepping_o
);
    typedef struct packed {
        logic [STEP_W-1:0] left;
        logic              halted;
    } step_st_t;

    step_st_t st_d, st_q;
    logic     budget_nz;

    always_comb begin
        st_d       = st_q;
        budget_nz  = (st_q.left != '0);
        may_exec_o = !hit_i && !st_q.halted && (run_always_i || budget_nz);
        stepping_o = budget_nz;
        if (rst) begin
            st_d = '0;
        end else if (hit_i) begin
            st_d.left   = '0;
            st_d.halted = 1'b1;
        end else if (go_i) begin
            st_d.left   = num_i;
            st_d.halted = 1'b0;
        end else if (may_exec_o && budget_nz) begin
            st_d.left = st_q.left - 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        st_q <= st_d;
    end

    // R6
    hit_clear_chk: assert property (@(posedge clk) disable iff (rst)
        hit_i |=> (!stepping_o && !may_exec_o));

    // R4
    load_chk: assert property (@(posedge clk) disable iff (rst)
        (go_i && !hit_i) |=> (stepping_o == ($past(num_i) != '0)));

    // R5
    count_down_chk: assert property (@(posedge clk) disable iff (rst)
        (may_exec_o && stepping_o && !go_i) |=> (st_q.left == $past(st_q.left) - 1'b1));

    // R7
    halt_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (st_q.halted && !go_i) |=> !may_exec_o);
endmodule

// File: rtl/dbg_step_gate.sv
module dbg_step_gate
    import dbg_pkg::*;
#(
    parameter int ADDR_W = 13,
    parameter int INSN_W = 14,
    parameter int STEP_W = 6
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [ADDR_W-1:0] pc_addr_i,
    input  logic [INSN_W-1:0] insn_i,
    input  logic [ADDR_W-1:0] watch_addr_i,
    input  logic [INSN_W-1:0] watch_insn_i,
    input  logic [WEN_W-1:0]  watch_en_i,
    input  logic [STEP_W-1:0] step_num_i,
    input  logic              step_go_i,
    input  logic              run_always_i,
    input  logic              hold_rst_i,
    output logic              may_exec_o,
    output logic              watch_hit_o,
    output logic              stepping_o,
    output logic              core_rst_o,
    output logic              core_clk_en_o
);
    logic addr_hit, insn_hit;

    dbg_watch_cmp #(.W(ADDR_W)) u_addr_cmp (
        .en_i   (watch_en_i[WEN_ADDR]),
        .live_i (pc_addr_i),
        .ref_i  (watch_addr_i),
        .hit_o  (addr_hit)
    );

    dbg_watch_cmp #(.W(INSN_W)) u_insn_cmp (
        .en_i   (watch_en_i[WEN_INSN]),
        .live_i (insn_i),
        .ref_i  (watch_insn_i),
        .hit_o  (insn_hit)
    );

    always_comb begin
        watch_hit_o   = addr_hit || insn_hit;
        core_rst_o    = rst || hold_rst_i;
        core_clk_en_o = may_exec_o || rst;
    end

    dbg_step_ctrl #(.STEP_W(STEP_W)) u_step (
        .clk          (clk),
        .rst          (rst),
        .hit_i        (watch_hit_o),
        .go_i         (step_go_i),
        .num_i        (step_num_i),
        .run_always_i (run_always_i),
        .may_exec_o   (may_exec_o),
        .stepping_o   (stepping_o)
    );

    // R10
    rst_clocks_chk: assert property (@(posedge clk)
        rst |-> core_clk_en_o);
endmodule

// File: tb/dbg_step_gate_tb.sv
`timescale 1ns/1ps
module dbg_step_gate_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [12:0] pc = '0, waddr = '0;
    logic [13:0] insn = '0, winsn = '0;
    logic [1:0]  wen = '0;
    logic [5:0]  num = '0;
    logic        go = 1'b0, ralw = 1'b0, hold = 1'b0;
    logic        may_exec, hit, stepping, crst, cclk;
    int          n_chk = 0, n_bad = 0;
    logic        done = 1'b0;

    always #2.5 clk = ~clk;

    dbg_step_gate u_dut (
        .clk(clk), .rst(rst), .pc_addr_i(pc), .insn_i(insn),
        .watch_addr_i(waddr), .watch_insn_i(winsn), .watch_en_i(wen),
        .step_num_i(num), .step_go_i(go), .run_always_i(ralw), .hold_rst_i(hold),
        .may_exec_o(may_exec), .watch_hit_o(hit), .stepping_o(stepping),
        .core_rst_o(crst), .core_clk_en_o(cclk)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
        end
    endtask

    task automatic start(input int n);
        @(negedge clk); num = 6'(n); go = 1'b1;
        @(negedge clk); go = 1'b0;
    endtask

    initial begin
        #(200000 * 5);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        chk("R11 stepping in reset", int'(stepping), 0);
        chk("R11 may_exec in reset", int'(may_exec), 0);
        chk("R9 core_rst in reset", int'(crst), 1);
        chk("R10 clk_en in reset", int'(cclk), 1);
        @(negedge clk); rst = 1'b0;
        #1;
        chk("R11 stepping after reset", int'(stepping), 0);
        chk("R11 may_exec after reset", int'(may_exec), 0);
        chk("R10 clk_en idle", int'(cclk), 0);
        chk("R9 core_rst idle", int'(crst), 0);

        // R4 R5: every budget 0..63
        for (int n = 0; n < 64; n++) begin
            int execs;
            start(n);
            #1;
            chk("R4 stepping after load", int'(stepping), int'(n != 0));
            execs = 0;
            for (int k = 0; k < 70; k++) begin
                if (may_exec) begin
                    execs++;
                    if (!cclk) chk("R10 clk_en follows exec", 0, 1);
                end
                @(negedge clk); #1;
            end
            chk("R5 exec cycles", execs, n);
            chk("R5 stepping at end", int'(stepping), 0);
        end

        // R1 R2 R3: enable x match sweep with single-bit mismatches
        for (int en = 0; en < 4; en++)
            for (int am = 0; am < 2; am++)
                for (int im = 0; im < 2; im++)
                    for (int b = 0; b < 14; b++) begin
                        @(negedge clk);
                        pc    = 13'(b * 613 + en * 37 + 5);
                        insn  = 14'(b * 1181 + am * 99 + 3);
                        wen   = 2'(en);
                        waddr = am ? pc : pc ^ 13'(1 << (b % 13));
                        winsn = im ? insn : insn ^ 14'(1 << b);
                        #1;
                        chk(am ? "R1 address watch" : "R3 address mismatch/disable",
                            int'(hit), int'((en[0] && am) || (en[1] && im)));
                        chk("R6 no exec in hit cycle", int'(hit && may_exec), 0);
                    end
        @(negedge clk); wen = '0;
        start(0);
        #1;
        chk("R11 idle after clear", int'(may_exec), 0);

        // R6 R7 R8: hit during a stepping run, then run-always resume
        pc = 13'h0AA; waddr = 13'h155;
        start(40);
        repeat (5) @(negedge clk);
        #1;
        chk("R5 mid run exec", int'(may_exec), 1);
        @(negedge clk); wen = 2'b01; waddr = pc;
        #1;
        chk("R1 hit mid run", int'(hit), 1);
        chk("R6 exec low on hit", int'(may_exec), 0);
        @(negedge clk); wen = 2'b00; ralw = 1'b1;
        #1;
        chk("R6 budget cleared", int'(stepping), 0);
        chk("R7 halted under run-always", int'(may_exec), 0);
        repeat (4) @(negedge clk);
        #1;
        chk("R7 still halted", int'(may_exec), 0);
        start(0);
        #1;
        chk("R8 resumes after strobe", int'(may_exec), 1);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk); #1;
            chk("R8 run-always every cycle", int'(may_exec), 1);
            chk("R8 budget zero", int'(stepping), 0);
        end
        // R6: instruction hit halts run-always
        @(negedge clk); wen = 2'b10; winsn = insn;
        #1;
        chk("R2 insn hit", int'(hit), 1);
        chk("R6 run-always halted by hit", int'(may_exec), 0);
        chk("R10 clk_en low on hit", int'(cclk), 0);
        @(negedge clk); wen = 2'b00; ralw = 1'b0;

        // R9 hold-reset combinations
        for (int v = 0; v < 4; v++) begin
            @(negedge clk); rst = v[0]; hold = v[1];
            #1;
            chk("R9 core_rst", int'(crst), int'(v != 0));
        end
        @(negedge clk); rst = 1'b0; hold = 1'b0;
        #1;
        chk("R11 state after reset", int'(may_exec), 0);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule